// File: doc/BRIEF.md
# Clock Reference Selector and Timing Mode Controller

This block is the decision logic of a two-input synchronous clock timing generator. It watches a qualified flag and an active flag for each reference. From those flags, from its selection settings and from a flag that says whether averaged holdover history exists, it decides two things. The first is which reference the phase-locked loop should follow. The second is the timing generator's operating mode: freerun, synchronized, pseudo-holdover or holdover. It also raises an external-timing indicator whenever the loop is locked to an outside reference.

Three selection styles are supported:

- **Automatic:** the priority elector alone decides.
- **Manual:** a register names a reference, or forces self-timing.
- **Pin-switched manual:** an asynchronous switch pin flips between two references that are programmed in advance.

The automatic elector keeps running in every style, so its memory stays current when control returns to it.

Top module: `refsel_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after its release, the outputs read `selRef`=0, `refValid`=0, `opMode`=0 (freerun) and `extTiming`=0.
- R2: All outputs are registered. They reflect non-pin inputs one clock edge after those inputs are applied. The `opMode` codes are 0 freerun, 1 synchronized, 2 pseudo-holdover and 3 holdover. The `selMode` codes are 0 automatic, 1 manual, 2 pin-switched, and 3 behaves as automatic.
- R3: In automatic selection, a reference is eligible when its qualified flag (bit i of `refQual`) is set and its priority is nonzero. A smaller nonzero priority value wins. Equal priorities go to reference 0.
- R4: With `revertEn` high, automatic selection always moves to the best eligible reference, including back to a better one that requalifies.
- R5: With `revertEn` low, automatic selection keeps its current reference for as long as that reference stays eligible.
- R6: When no reference can be selected, `refValid` is 0 and `selRef` holds its last value. `opMode` is then holdover if `histValid` is set, and freerun otherwise.
- R7: In manual mode, `manChoice` 0 or 1 selects that reference whatever the elector prefers. `manChoice` 2 forces self-timing, giving holdover (or freerun without history). `manChoice` 3 forces freerun. For codes 2 and 3, `refValid` is 0.
- R8: In pin-switched mode, synchronized `swPin` low selects `pinRefLow` and high selects `pinRefHigh`. `refValid` is 1. A pin edge reaches `selRef` SYNC_STAGES+1 edges later, whereas a change of the programmed references takes one edge.
- R9: For a selected reference, the mode depends on its two flags:
  - qualified and active gives synchronized;
  - qualified but inactive gives pseudo-holdover;
  - not qualified gives holdover if `histValid` is set, and freerun otherwise.
- R10: `extTiming` is 1 exactly when `opMode` is synchronized.
- R11: The elector keeps updating its memory while manual or pin-switched mode is in force. On return to automatic, non-revertive selection keeps whatever the elector last tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rstN | input | 1 | asynchronous active-low reset |
| refQual | input | 2 | qualified flag per reference (bit i = reference i) |
| refActive | input | 2 | activity flag per reference |
| prioRef0 | input | PRIO_W | priority of reference 0; 0 excludes it |
| prioRef1 | input | PRIO_W | priority of reference 1; 0 excludes it |
| revertEn | input | 1 | revertive automatic selection |
| selMode | input | 2 | selection style |
| manChoice | input | 2 | manual selection code |
| pinRefLow | input | 1 | reference used when the switch pin is low |
| pinRefHigh | input | 1 | reference used when the switch pin is high |
| swPin | input | 1 | asynchronous switch pin |
| histValid | input | 1 | holdover history available |
| selRef | output | 1 | selected reference index |
| refValid | output | 1 | a reference is selected |
| opMode | output | 2 | operating mode |
| extTiming | output | 1 | external timing indicator |

## Verification
The bench walks one stateful sequence in which each step depends on the one before it, because non-revertive selection remembers its choice. A design that re-elected from scratch every cycle would jump back to reference 0 in the step where the bench expects it to stay on reference 1. Ties and zero priorities are probed: a design that favoured the higher index, or treated zero as top priority, would pick the wrong input. Loss of every reference is checked against `selRef`, which must hold its last value; a design that cleared it would read back 0 where the bench expects 1. The pin path is sampled one edge before and at the expected edge, which exposes a missing or extra synchronizer stage. A sequence in manual mode disqualifies the elector's choice and then returns to automatic, so an elector frozen during manual control would resurface on the stale reference.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    SEL_AUTO   = 2'd0,
    SEL_MANUAL = 2'd1,
    SEL_PIN    = 2'd2,
    SEL_SPARE  = 2'd3
  } selMode_e;

  typedef enum logic [1:0] {
    OP_FREERUN  = 2'd0,
    OP_SYNC     = 2'd1,
    OP_PSEUDO   = 2'd2,
    OP_HOLDOVER = 2'd3
  } opMode_e;

  localparam logic [1:0] MAN_HOLD = 2'd2;
  localparam logic [1:0] MAN_FREE = 2'd3;

  // strobes from control to datapath: which source feeds the selection
  typedef struct packed {
    logic takeAuto;
    logic takeManual;
    logic takePin;
    logic forceHold;
    logic forceFree;
  } pickStrobe_t;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES:0] chain;
  assign chain[0] = dIn;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s+1] <= 1'b0;
      else       chain[s+1] <= chain[s];
    end
  end

  assign dOut = chain[STAGES];
endmodule

// File: rtl/refsel_elector.sv
module refsel_elector #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        refQual,
  input  logic [PRIO_W-1:0] prioRef0,
  input  logic [PRIO_W-1:0] prioRef1,
  input  logic              revertEn,
  output logic              autoRef,
  output logic              autoHave
);
  localparam int REF_CNT = 2;

  logic [PRIO_W-1:0]  prioArr [REF_CNT];
  logic [REF_CNT-1:0] elig;
  logic               freshRef;
  logic               keepHeld;
  logic               heldRef;
  logic               heldHave;

  assign prioArr[0] = prioRef0;
  assign prioArr[1] = prioRef1;

  for (genvar g = 0; g < REF_CNT; g++) begin : g_elig
    assign elig[g] = refQual[g] && (prioArr[g] != '0);
  end

  always_comb begin
    // smaller nonzero value wins; ties fall to the lower index
    if (elig[0] && elig[1]) freshRef = (prioArr[1] < prioArr[0]);
    else                    freshRef = elig[1];
    keepHeld = !revertEn && heldHave && elig[heldRef];
    autoRef  = keepHeld ? heldRef : freshRef;
    autoHave = |elig;
  end

  // memory of the elector's own result, updated in every selection style
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldRef  <= 1'b0;
      heldHave <= 1'b0;
    end else begin
      heldHave <= autoHave;
      if (autoHave) heldRef <= autoRef;
    end
  end
endmodule

// File: rtl/refsel_datapath.sv
module refsel_datapath
  import refsel_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        refQual,
  input  logic [1:0]        refActive,
  input  logic [PRIO_W-1:0] prioRef0,
  input  logic [PRIO_W-1:0] prioRef1,
  input  logic              revertEn,
  input  logic              manRef,
  input  logic              pinRefLow,
  input  logic              pinRefHigh,
  input  logic              swSync,
  input  pickStrobe_t       strobe,
  output logic              selRef,
  output logic              refValid,
  output logic              candHave,
  output logic              candQual,
  output logic              candAct
);
  logic autoRef;
  logic autoHave;
  logic candRef;

  refsel_elector #(.PRIO_W(PRIO_W)) elector_i (
    .clk      (clk),
    .rstN     (rstN),
    .refQual  (refQual),
    .prioRef0 (prioRef0),
    .prioRef1 (prioRef1),
    .revertEn (revertEn),
    .autoRef  (autoRef),
    .autoHave (autoHave)
  );

  always_comb begin
    if (strobe.takeManual) begin
      candRef  = manRef;
      candHave = 1'b1;
    end else if (strobe.takePin) begin
      candRef  = swSync ? pinRefHigh : pinRefLow;
      candHave = 1'b1;
    end else if (strobe.takeAuto) begin
      candRef  = autoRef;
      candHave = autoHave;
    end else begin
      candRef  = selRef;
      candHave = 1'b0;
    end
    candQual = refQual[candRef];
    candAct  = refActive[candRef];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selRef   <= 1'b0;
      refValid <= 1'b0;
    end else begin
      refValid <= candHave;
      if (candHave) selRef <= candRef;
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  selMode,
  input  logic [1:0]  manChoice,
  input  logic        histValid,
  input  logic        candHave,
  input  logic        candQual,
  input  logic        candAct,
  output pickStrobe_t strobe,
  output logic [1:0]  opMode,
  output logic        extTiming
);
  opMode_e nextMode;
  opMode_e selfMode;

  always_comb begin
    strobe = '0;
    unique case (selMode_e'(selMode))
      SEL_MANUAL: begin
        if (manChoice == MAN_FREE)      strobe.forceFree  = 1'b1;
        else if (manChoice == MAN_HOLD) strobe.forceHold  = 1'b1;
        else                            strobe.takeManual = 1'b1;
      end
      SEL_PIN: strobe.takePin = 1'b1;
      default: strobe.takeAuto = 1'b1;
    endcase
  end

  always_comb begin
    selfMode = histValid ? OP_HOLDOVER : OP_FREERUN;
    if (strobe.forceFree)   nextMode = OP_FREERUN;
    else if (!candHave)     nextMode = selfMode;
    else if (!candQual)     nextMode = selfMode;
    else if (!candAct)      nextMode = OP_PSEUDO;
    else                    nextMode = OP_SYNC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opMode    <= OP_FREERUN;
      extTiming <= 1'b0;
    end else begin
      opMode    <= nextMode;
      extTiming <= (nextMode == OP_SYNC);
    end
  end
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int PRIO_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        refQual,
  input  logic [1:0]        refActive,
  input  logic [PRIO_W-1:0] prioRef0,
  input  logic [PRIO_W-1:0] prioRef1,
  input  logic              revertEn,
  input  logic [1:0]        selMode,
  input  logic [1:0]        manChoice,
  input  logic              pinRefLow,
  input  logic              pinRefHigh,
  input  logic              swPin,
  input  logic              histValid,
  output logic              selRef,
  output logic              refValid,
  output logic [1:0]        opMode,
  output logic              extTiming
);
  logic        swSync;
  pickStrobe_t strobe;
  logic        candHave;
  logic        candQual;
  logic        candAct;

  refsel_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (swPin),
    .dOut (swSync)
  );

  refsel_datapath #(.PRIO_W(PRIO_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .refQual    (refQual),
    .refActive  (refActive),
    .prioRef0   (prioRef0),
    .prioRef1   (prioRef1),
    .revertEn   (revertEn),
    .manRef     (manChoice[0]),
    .pinRefLow  (pinRefLow),
    .pinRefHigh (pinRefHigh),
    .swSync     (swSync),
    .strobe     (strobe),
    .selRef     (selRef),
    .refValid   (refValid),
    .candHave   (candHave),
    .candQual   (candQual),
    .candAct    (candAct)
  );

  refsel_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .selMode   (selMode),
    .manChoice (manChoice),
    .histValid (histValid),
    .candHave  (candHave),
    .candQual  (candQual),
    .candAct   (candAct),
    .strobe    (strobe),
    .opMode    (opMode),
    .extTiming (extTiming)
  );
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker #(
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        refQual,
  input logic [PRIO_W-1:0] prioRef0,
  input logic [PRIO_W-1:0] prioRef1,
  input logic [1:0]        selMode,
  input logic [1:0]        manChoice,
  input logic              histValid,
  input logic              selRef,
  input logic              refValid,
  input logic [1:0]        opMode,
  input logic              extTiming
);
  AST_EXT_IMPLIES_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    extTiming |-> (opMode == 2'd1) && refValid); // R10

  AST_NO_HISTORY_NO_HOLDOVER: assert property (@(posedge clk) disable iff (!rstN)
    !histValid |=> (opMode != 2'd3)); // R6

  AST_NO_QUAL_NO_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (refQual == 2'b00) |=> !extTiming); // R9

  AST_FORCED_FREERUN: assert property (@(posedge clk) disable iff (!rstN)
    (selMode == 2'd1 && manChoice == 2'd3) |=> (opMode == 2'd0) && !refValid); // R7

  AST_PIN_HAS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (selMode == 2'd2) |=> refValid); // R8

  AST_EXCLUDED_NOT_ELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (selMode == 2'd0 && prioRef0 == '0 && prioRef1 == '0) |=> !refValid); // R3

  AST_REF_HELD_ON_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refValid) |-> $stable(selRef)); // R6
endmodule

bind refsel_top refsel_checker #(.PRIO_W(PRIO_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .refQual   (refQual),
  .prioRef0  (prioRef0),
  .prioRef1  (prioRef1),
  .selMode   (selMode),
  .manChoice (manChoice),
  .histValid (histValid),
  .selRef    (selRef),
  .refValid  (refValid),
  .opMode    (opMode),
  .extTiming (extTiming)
);

// File: tb/refsel_top_tb_top.sv
module refsel_top_tb_top;
  localparam int PRIO_W = 4;
  localparam int SYNC_STAGES = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        refQual = 2'b00;
  logic [1:0]        refActive = 2'b00;
  logic [PRIO_W-1:0] prioRef0 = 4'd1;
  logic [PRIO_W-1:0] prioRef1 = 4'd2;
  logic              revertEn = 1'b1;
  logic [1:0]        selMode = 2'd0;
  logic [1:0]        manChoice = 2'd0;
  logic              pinRefLow = 1'b0;
  logic              pinRefHigh = 1'b1;
  logic              swPin = 1'b0;
  logic              histValid = 1'b0;
  logic              selRef;
  logic              refValid;
  logic [1:0]        opMode;
  logic              extTiming;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  refsel_top #(.PRIO_W(PRIO_W), .SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk(clk), .rstN(rstN), .refQual(refQual), .refActive(refActive),
    .prioRef0(prioRef0), .prioRef1(prioRef1), .revertEn(revertEn),
    .selMode(selMode), .manChoice(manChoice), .pinRefLow(pinRefLow),
    .pinRefHigh(pinRefHigh), .swPin(swPin), .histValid(histValid),
    .selRef(selRef), .refValid(refValid), .opMode(opMode), .extTiming(extTiming)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] man;
    logic       rev;
    logic       hist;
    logic [1:0] q;
    logic [1:0] a;
    logic [3:0] p0;
    logic [3:0] p1;
    logic       eRef;
    logic       eVal;
    logic [1:0] eMode;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0,2'd0,1'b1,1'b0,2'b00,2'b00,4'd1,4'd2,1'b0,1'b0,2'd0,4'd6},  // R6 nothing, no history
    '{2'd0,2'd0,1'b1,1'b1,2'b00,2'b00,4'd1,4'd2,1'b0,1'b0,2'd3,4'd6},  // R6 nothing, history
    '{2'd0,2'd0,1'b1,1'b1,2'b10,2'b10,4'd1,4'd2,1'b1,1'b1,2'd1,4'd3},  // R3 only ref1
    '{2'd0,2'd0,1'b1,1'b1,2'b11,2'b11,4'd1,4'd2,1'b0,1'b1,2'd1,4'd4},  // R4 revert to ref0
    '{2'd0,2'd0,1'b1,1'b1,2'b11,2'b10,4'd1,4'd2,1'b0,1'b1,2'd2,4'd9},  // R9 pseudo-holdover
    '{2'd0,2'd0,1'b0,1'b1,2'b10,2'b11,4'd1,4'd2,1'b1,1'b1,2'd1,4'd5},  // R5 move to ref1
    '{2'd0,2'd0,1'b0,1'b1,2'b11,2'b11,4'd1,4'd2,1'b1,1'b1,2'd1,4'd5},  // R5 keep ref1
    '{2'd0,2'd0,1'b1,1'b1,2'b11,2'b11,4'd1,4'd2,1'b0,1'b1,2'd1,4'd4},  // R4 revert
    '{2'd0,2'd0,1'b1,1'b1,2'b11,2'b11,4'd0,4'd2,1'b1,1'b1,2'd1,4'd3},  // R3 zero excludes
    '{2'd0,2'd0,1'b1,1'b1,2'b11,2'b11,4'd3,4'd3,1'b0,1'b1,2'd1,4'd3},  // R3 tie to ref0
    '{2'd0,2'd0,1'b1,1'b1,2'b11,2'b11,4'd3,4'd1,1'b1,1'b1,2'd1,4'd3},  // R3 smaller wins
    '{2'd0,2'd0,1'b1,1'b1,2'b00,2'b11,4'd3,4'd1,1'b1,1'b0,2'd3,4'd6},  // R6 held index
    '{2'd1,2'd0,1'b1,1'b1,2'b11,2'b11,4'd3,4'd1,1'b0,1'b1,2'd1,4'd7},  // R7 manual overrides
    '{2'd1,2'd0,1'b1,1'b1,2'b10,2'b11,4'd3,4'd1,1'b0,1'b1,2'd3,4'd9},  // R9 unqualified, hist
    '{2'd1,2'd0,1'b1,1'b0,2'b10,2'b11,4'd3,4'd1,1'b0,1'b1,2'd0,4'd9},  // R9 unqualified, none
    '{2'd1,2'd2,1'b1,1'b1,2'b11,2'b11,4'd3,4'd1,1'b0,1'b0,2'd3,4'd7},  // R7 forced holdover
    '{2'd1,2'd2,1'b1,1'b0,2'b11,2'b11,4'd3,4'd1,1'b0,1'b0,2'd0,4'd7},  // R7 forced hold, no hist
    '{2'd1,2'd3,1'b1,1'b1,2'b11,2'b11,4'd3,4'd1,1'b0,1'b0,2'd0,4'd7},  // R7 forced freerun
    '{2'd2,2'd0,1'b1,1'b1,2'b11,2'b11,4'd3,4'd1,1'b0,1'b1,2'd1,4'd8},  // R8 pin low
    '{2'd3,2'd0,1'b1,1'b1,2'b11,2'b11,4'd3,4'd1,1'b1,1'b1,2'd1,4'd2}   // R2 spare code as auto
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic eRef, input logic eVal,
                          input logic [1:0] eMode);
    check({tag, " selRef"}, int'(selRef), int'(eRef));
    check({tag, " refValid"}, int'(refValid), int'(eVal));
    check({tag, " opMode"}, int'(opMode), int'(eMode));
    check({tag, " extTiming (R10)"}, int'(extTiming), int'(eMode == 2'd1));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin : main
    // R1 reset state
    @(negedge clk);
    checkAll("R1 in reset", 1'b0, 1'b0, 2'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release", 1'b0, 1'b0, 2'd0);

    for (int i = 0; i < NVEC; i++) begin
      selMode   = VECS[i].mode;
      manChoice = VECS[i].man;
      revertEn  = VECS[i].rev;
      histValid = VECS[i].hist;
      refQual   = VECS[i].q;
      refActive = VECS[i].a;
      prioRef0  = VECS[i].p0;
      prioRef1  = VECS[i].p1;
      @(negedge clk);
      checkAll($sformatf("R%0d vector %0d", VECS[i].req, i),
               VECS[i].eRef, VECS[i].eVal, VECS[i].eMode);
    end

    // R8 pin latency: SYNC_STAGES+1 edges
    selMode = 2'd2; refQual = 2'b11; refActive = 2'b11; histValid = 1'b1;
    pinRefLow = 1'b0; pinRefHigh = 1'b1;
    swPin = 1'b1;
    for (int k = 1; k <= SYNC_STAGES; k++) begin
      @(negedge clk);
      check($sformatf("R8 pin edge +%0d still low ref", k), int'(selRef), 0);
    end
    @(negedge clk);
    check("R8 pin edge reaches selRef", int'(selRef), 1);
    // R8 reprogrammed references act after one edge
    pinRefLow = 1'b1; pinRefHigh = 1'b0;
    @(negedge clk);
    check("R8 reprogrammed high ref", int'(selRef), 0);
    check("R8 refValid", int'(refValid), 1);

    // R11 elector keeps tracking under manual control
    revertEn = 1'b0; prioRef0 = 4'd2; prioRef1 = 4'd1;
    selMode = 2'd0; refQual = 2'b01;
    @(negedge clk);
    check("R11 auto starts on ref0", int'(selRef), 0);
    selMode = 2'd1; manChoice = 2'd1; refQual = 2'b11;
    @(negedge clk);
    check("R7 manual ignores elector", int'(selRef), 1);
    refQual = 2'b10;
    @(negedge clk);
    check("R11 manual holds ref1", int'(selRef), 1);
    refQual = 2'b11;
    @(negedge clk);
    selMode = 2'd0;
    @(negedge clk);
    check("R11 elector tracked ref1", int'(selRef), 1);
    check("R5 non-revertive kept", int'(opMode), 1);

    // R1 reset in mid-run
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R1 mid-run reset", 1'b0, 1'b0, 2'd0);
    rstN = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule